// File: doc/BRIEF.md
# Multi-Mode Console I/O Port Decoder

This block sits between an 8-bit CPU's I/O bus and the peripherals of a family of related game consoles. A mode input selects one of five console variants. On an I/O write it raises a single select toward one peripheral, or none. It also keeps the memory-control register, which software writes through the same bus. On an I/O read it chooses the byte that goes back to the CPU. That byte comes from one of the peripheral read-data inputs or from an open-bus value.

Only the low byte of the 16-bit port address is decoded. Writes look at address bits 7, 6 and 0. Reads look at bits 7 and 6. Some modes add exact-address overrides, and these win over the masked decode. The open-bus value is the last opcode byte the CPU fetched, which the core supplies. Two masks then adjust it: one forces bits high, the other forces bits low. Both masks live in registers that reset to zero.

The mode codes are 0 (standard), 1 (FM-equipped variant), 2 (handheld native), 3 (handheld in compatibility mode) and 4 (16-bit console compatibility). Codes 5 to 7 decode as code 0.

Top module: `ioPortDecoder`

## Requirements
- R1: A write strobe selects a peripheral from low-address bits {7,6,0}. 000 selects memory control, 001 selects I/O control, 01x selects the sound chip and 10x selects the video chip. Address bits 15..8 never affect the decode.
- R2: A write whose bits {7,6} are 11 raises no select, unless an override in R4 or R6 applies.
- R3: A read returns a value chosen by low-address bits {7,6}. 00 gives open bus, 01 gives the video counter input, 10 gives the video data input and 11 gives the controller input. R5, R6 and R7 modify this.
- R4: In mode 1, writes to low addresses 0xF0 and 0xF1 select the FM unit with fmAddr 0 and 1 respectively. A write to 0xF2 selects the FM detect latch. These override R1 and R2.
- R5: In mode 1, a read of 0xF2 returns the FM detect input while bit 2 of the memory-control register is 0. When that bit is 1, R3 applies.
- R6: In mode 2, low addresses 0x00 to 0x06 go to the serial port for both reads and writes. This overrides every other rule.
- R7: In modes 2, 3 and 4, a read in region 11 returns the controller input only at 0xC0, 0xC1, 0xDC and 0xDD. Every other address in that region returns open bus.
- R8: In mode 4, a write to the memory-control pattern raises no select and leaves the memory-control register unchanged.
- R9: Open bus equals (lastOpcode OR pull-up mask) AND NOT pull-down mask. Both masks reset to 0x00 and are loaded from maskUpIn and maskDownIn on a clock edge with maskLoad high.
- R10: Selects are high only while wrStrobe is high, and at most one is high at a time. The memory-control register resets to 0x00 and takes wrData on the clock edge of a memory-control select.
- R11: rdData is 0x00 whenever rdStrobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Console variant code |
| portAddr | input | 16 | I/O port address |
| wrStrobe | input | 1 | I/O write access |
| rdStrobe | input | 1 | I/O read access |
| wrData | input | 8 | Write data |
| lastOpcode | input | 8 | Last opcode byte fetched by the CPU |
| maskLoad | input | 1 | Load the open-bus masks |
| maskUpIn | input | 8 | New pull-up mask |
| maskDownIn | input | 8 | New pull-down mask |
| vidCountIn | input | 8 | Video counter read data |
| vidDataIn | input | 8 | Video data/status read data |
| padIn | input | 8 | Controller input read data |
| fmDetectIn | input | 8 | FM detect read data |
| serialIn | input | 8 | Serial port read data |
| selMemCtrl | output | 1 | Memory-control write select |
| selIoCtrl | output | 1 | I/O-control write select |
| selSound | output | 1 | Sound chip write select |
| selVideo | output | 1 | Video chip write select |
| selFmUnit | output | 1 | FM unit write select |
| fmAddr | output | 1 | FM unit register address (0 or 1) |
| selFmDetect | output | 1 | FM detect latch write select |
| selSerial | output | 1 | Serial port write select |
| memCtrl | output | 8 | Memory-control register |
| rdData | output | 8 | Read data to the CPU |

## Verification
The bench sweeps all 256 low addresses in every mode, for writes and for reads, with a changing upper byte. A decoder that used the read mask for writes, let the upper byte in, or put the overrides in the wrong mode or priority would show a wrong select or wrong data at some address. For the FM detect read, the bench toggles memory-control bit 2 through a real write; a decoder that ignored the gate would return the FM detect value instead of the pads. The bench also tries a memory-control write in 16-bit compatibility mode and then loads open-bus masks that overlap. A register that still updated, or masks applied in the wrong order (pull-down must win), would show up on memCtrl or on rdData.

// File: rtl/ioPortDecoderPkg.sv
package ioPortDecoderPkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_BASE    = 3'd0;
  localparam logic [MODE_W-1:0] MODE_FM      = 3'd1;
  localparam logic [MODE_W-1:0] MODE_HAND    = 3'd2;
  localparam logic [MODE_W-1:0] MODE_HANDCMP = 3'd3;
  localparam logic [MODE_W-1:0] MODE_WIDECMP = 3'd4;

  typedef enum logic [2:0] {
    SRC_OPEN, SRC_VCOUNT, SRC_VDATA, SRC_PAD, SRC_FMDET, SRC_SERIAL
  } rdSrcE;

  typedef struct packed {
    logic  wrMemCtrl;
    logic  wrIo;
    logic  wrSound;
    logic  wrVideo;
    logic  wrFm;
    logic  fmAddr;
    logic  wrFmDet;
    logic  wrSerial;
    logic  rdEn;
    rdSrcE rdSrc;
  } ctrlStrobesT;
endpackage

// File: rtl/ioDecodeCtrl.sv
module ioDecodeCtrl
  import ioPortDecoderPkg::*;
#(
  parameter int FM_GATE_BIT = 2,
  parameter int SERIAL_LAST = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] mode,
  input  logic [7:0]        lowAddr,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic [DATA_W-1:0] memCtrl,
  output ctrlStrobesT       strobes
);
  logic isFm, isHand, padRestrict, inSerial;

  assign isFm        = (mode == MODE_FM);
  assign isHand      = (mode == MODE_HAND);
  assign padRestrict = (mode == MODE_HAND) || (mode == MODE_HANDCMP) || (mode == MODE_WIDECMP);
  assign inSerial    = isHand && (lowAddr <= 8'(SERIAL_LAST));

  always_comb begin
    strobes = '0;
    strobes.rdSrc = SRC_OPEN;
    strobes.rdEn  = rdStrobe;
    // write decode
    if (wrStrobe) begin
      if (inSerial) begin
        strobes.wrSerial = 1'b1;
      end else if (isFm && (lowAddr == 8'hF0 || lowAddr == 8'hF1)) begin
        strobes.wrFm   = 1'b1;
        strobes.fmAddr = lowAddr[0];
      end else if (isFm && lowAddr == 8'hF2) begin
        strobes.wrFmDet = 1'b1;
      end else begin
        unique case ({lowAddr[7:6], lowAddr[0]})
          3'b000:         strobes.wrMemCtrl = (mode != MODE_WIDECMP);
          3'b001:         strobes.wrIo      = 1'b1;
          3'b010, 3'b011: strobes.wrSound   = 1'b1;
          3'b100, 3'b101: strobes.wrVideo   = 1'b1;
          default: ;
        endcase
      end
    end
    // read decode
    if (inSerial) begin
      strobes.rdSrc = SRC_SERIAL;
    end else if (isFm && lowAddr == 8'hF2 && !memCtrl[FM_GATE_BIT]) begin
      strobes.rdSrc = SRC_FMDET;
    end else begin
      unique case (lowAddr[7:6])
        2'b00: strobes.rdSrc = SRC_OPEN;
        2'b01: strobes.rdSrc = SRC_VCOUNT;
        2'b10: strobes.rdSrc = SRC_VDATA;
        default: begin
          if (!padRestrict || lowAddr == 8'hC0 || lowAddr == 8'hC1 ||
              lowAddr == 8'hDC || lowAddr == 8'hDD)
            strobes.rdSrc = SRC_PAD;
          else
            strobes.rdSrc = SRC_OPEN;
        end
      endcase
    end
  end

  a_r10_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.wrMemCtrl, strobes.wrIo, strobes.wrSound, strobes.wrVideo,
                strobes.wrFm, strobes.wrFmDet, strobes.wrSerial}) <= 1);
  a_r10_no_strobe_no_select: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> !(strobes.wrMemCtrl || strobes.wrIo || strobes.wrSound || strobes.wrVideo ||
                    strobes.wrFm || strobes.wrFmDet || strobes.wrSerial));
  a_r6_serial_only_handheld: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrSerial |-> (mode == MODE_HAND));
endmodule

// File: rtl/ioDecodeDatapath.sv
module ioDecodeDatapath
  import ioPortDecoderPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] mode,
  input  ctrlStrobesT       strobes,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] lastOpcode,
  input  logic              maskLoad,
  input  logic [DATA_W-1:0] maskUpIn,
  input  logic [DATA_W-1:0] maskDownIn,
  input  logic [DATA_W-1:0] vidCountIn,
  input  logic [DATA_W-1:0] vidDataIn,
  input  logic [DATA_W-1:0] padIn,
  input  logic [DATA_W-1:0] fmDetectIn,
  input  logic [DATA_W-1:0] serialIn,
  output logic [DATA_W-1:0] memCtrl,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] pullUp, pullDown, openBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCtrl  <= '0;
      pullUp   <= '0;
      pullDown <= '0;
    end else begin
      if (strobes.wrMemCtrl) memCtrl <= wrData;
      if (maskLoad) begin
        pullUp   <= maskUpIn;
        pullDown <= maskDownIn;
      end
    end
  end

  assign openBus = (lastOpcode | pullUp) & ~pullDown;

  always_comb begin
    rdData = '0;
    if (strobes.rdEn) begin
      unique case (strobes.rdSrc)
        SRC_VCOUNT: rdData = vidCountIn;
        SRC_VDATA:  rdData = vidDataIn;
        SRC_PAD:    rdData = padIn;
        SRC_FMDET:  rdData = fmDetectIn;
        SRC_SERIAL: rdData = serialIn;
        default:    rdData = openBus;
      endcase
    end
  end

  a_r8_wide_keeps_memctrl: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && mode == MODE_WIDECMP) |=> $stable(memCtrl));
  a_r10_memctrl_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrMemCtrl |=> $stable(memCtrl));
  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |-> (rdData == '0));
  a_r9_pull_down_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdEn && strobes.rdSrc == SRC_OPEN) |-> ((rdData & pullDown) == '0));
endmodule

// File: rtl/ioPortDecoder.sv
module ioPortDecoder
  import ioPortDecoderPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] lastOpcode,
  input  logic              maskLoad,
  input  logic [DATA_W-1:0] maskUpIn,
  input  logic [DATA_W-1:0] maskDownIn,
  input  logic [DATA_W-1:0] vidCountIn,
  input  logic [DATA_W-1:0] vidDataIn,
  input  logic [DATA_W-1:0] padIn,
  input  logic [DATA_W-1:0] fmDetectIn,
  input  logic [DATA_W-1:0] serialIn,
  output logic              selMemCtrl,
  output logic              selIoCtrl,
  output logic              selSound,
  output logic              selVideo,
  output logic              selFmUnit,
  output logic              fmAddr,
  output logic              selFmDetect,
  output logic              selSerial,
  output logic [DATA_W-1:0] memCtrl,
  output logic [DATA_W-1:0] rdData
);
  ctrlStrobesT strobes;
  logic unusedUpper;
  assign unusedUpper = ^portAddr[ADDR_W-1:8];

  ioDecodeCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mode), .lowAddr(portAddr[7:0]),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .memCtrl(memCtrl), .strobes(strobes)
  );

  ioDecodeDatapath dp_i (
    .clk(clk), .rstN(rstN), .mode(mode), .strobes(strobes), .wrStrobe(wrStrobe),
    .wrData(wrData), .lastOpcode(lastOpcode), .maskLoad(maskLoad),
    .maskUpIn(maskUpIn), .maskDownIn(maskDownIn), .vidCountIn(vidCountIn),
    .vidDataIn(vidDataIn), .padIn(padIn), .fmDetectIn(fmDetectIn),
    .serialIn(serialIn), .memCtrl(memCtrl), .rdData(rdData)
  );

  assign selMemCtrl  = strobes.wrMemCtrl;
  assign selIoCtrl   = strobes.wrIo;
  assign selSound    = strobes.wrSound;
  assign selVideo    = strobes.wrVideo;
  assign selFmUnit   = strobes.wrFm;
  assign fmAddr      = strobes.fmAddr;
  assign selFmDetect = strobes.wrFmDet;
  assign selSerial   = strobes.wrSerial;
endmodule

// File: tb/ioPortDecoder_tb_top.sv
module ioPortDecoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] mode = '0;
  logic [15:0] portAddr = '0;
  logic wrStrobe = 1'b0, rdStrobe = 1'b0, maskLoad = 1'b0;
  logic [7:0] wrData = '0, lastOpcode = 8'h9C, maskUpIn = '0, maskDownIn = '0;
  logic [7:0] vidCountIn = 8'h11, vidDataIn = 8'h22, padIn = 8'h33;
  logic [7:0] fmDetectIn = 8'h44, serialIn = 8'h55;
  logic selMemCtrl, selIoCtrl, selSound, selVideo, selFmUnit, fmAddr, selFmDetect, selSerial;
  logic [7:0] memCtrl, rdData;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ioPortDecoder dut_i (.*);

  // select vector order: {serial, fmDetect, fmUnit, video, sound, io, memCtrl}
  localparam logic [6:0] S_NONE = 7'd0, S_MEM = 7'd1, S_IO = 7'd2, S_SND = 7'd4,
                         S_VID = 7'd8, S_FM = 7'd16, S_FMD = 7'd32, S_SER = 7'd64;

  function automatic logic [6:0] refWrite(input logic [2:0] m, input logic [7:0] a);
    if (m == 3'd2 && a <= 8'd6) return S_SER;                   // R6
    if (m == 3'd1 && (a == 8'hF0 || a == 8'hF1)) return S_FM;   // R4
    if (m == 3'd1 && a == 8'hF2) return S_FMD;                  // R4
    case ({a[7:6], a[0]})
      3'b000: return (m == 3'd4) ? S_NONE : S_MEM;              // R1, R8
      3'b001: return S_IO;
      3'b010, 3'b011: return S_SND;
      3'b100, 3'b101: return S_VID;
      default: return S_NONE;                                   // R2
    endcase
  endfunction

  function automatic logic [7:0] refRead(input logic [2:0] m, input logic [7:0] a,
                                         input logic gate, input logic [7:0] ob);
    if (m == 3'd2 && a <= 8'd6) return serialIn;                // R6
    if (m == 3'd1 && a == 8'hF2 && !gate) return fmDetectIn;    // R5
    case (a[7:6])
      2'b00: return ob;
      2'b01: return vidCountIn;
      2'b10: return vidDataIn;
      default: begin                                            // R3, R7
        if (m == 3'd2 || m == 3'd3 || m == 3'd4) begin
          if (a == 8'hC0 || a == 8'hC1 || a == 8'hDC || a == 8'hDD) return padIn;
          return ob;
        end
        return padIn;
      end
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s mode=%0d addr=%h actual=%h expected=%h", req, mode, portAddr, act, exp);
    end
  endtask

  function automatic logic [6:0] selVec();
    return {selSerial, selFmDetect, selFmUnit, selVideo, selSound, selIoCtrl, selMemCtrl};
  endfunction

  task automatic memWrite(input logic [7:0] d);
    @(negedge clk);
    mode = 3'd0; portAddr = 16'h3E00; wrData = d; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic testReset();
    #1;
    check("R10 reset memCtrl", {8'h0, memCtrl}, 16'h0000);
    check("R10 reset selects", {9'h0, selVec()}, 16'h0000);
    check("R11 idle rdData", {8'h0, rdData}, 16'h0000);
    rdStrobe = 1'b1; portAddr = 16'h0010; #1;
    check("R9 reset masks open bus", {8'h0, rdData}, {8'h0, lastOpcode});
    rdStrobe = 1'b0;
  endtask

  task automatic sweepWrites();
    for (int m = 0; m < 5; m++) begin
      for (int a = 0; a < 256; a++) begin
        @(negedge clk);
        mode = 3'(m); portAddr = {8'(a * 37 + m), 8'(a)}; wrData = 8'h00; wrStrobe = 1'b1;
        #1;
        check("R1 R2 R4 R6 R8 write select", {9'h0, selVec()}, {9'h0, refWrite(3'(m), 8'(a))});
        if (selFmUnit) check("R4 fm address", {15'h0, fmAddr}, {15'h0, a[0]});
      end
    end
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic sweepReads(input logic [7:0] mcVal);
    memWrite(mcVal);
    check("R10 memCtrl loaded", {8'h0, memCtrl}, {8'h0, mcVal});
    for (int m = 0; m < 5; m++) begin
      for (int a = 0; a < 256; a++) begin
        @(negedge clk);
        mode = 3'(m); portAddr = {8'(a * 91 + 3), 8'(a)}; rdStrobe = 1'b1;
        #1;
        check("R3 R5 R6 R7 read data", {8'h0, rdData},
              {8'h0, refRead(3'(m), 8'(a), mcVal[2], lastOpcode)});
        check("R10 no select on read", {9'h0, selVec()}, 16'h0000);
      end
    end
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic testFmGate();
    memWrite(8'h04);
    @(negedge clk);
    mode = 3'd1; portAddr = 16'h00F2; rdStrobe = 1'b1; #1;
    check("R5 gate set gives pads", {8'h0, rdData}, {8'h0, padIn});
    rdStrobe = 1'b0;
    memWrite(8'hFB);
    @(negedge clk);
    mode = 3'd1; portAddr = 16'hA5F2; rdStrobe = 1'b1; #1;
    check("R5 gate clear gives fm detect", {8'h0, rdData}, {8'h0, fmDetectIn});
    rdStrobe = 1'b0;
  endtask

  task automatic testWideMemCtrl();
    memWrite(8'h5A);
    @(negedge clk);
    mode = 3'd4; portAddr = 16'h0000; wrData = 8'hC3; wrStrobe = 1'b1; #1;
    check("R8 no select", {15'h0, selMemCtrl}, 16'h0000);
    @(negedge clk);
    wrStrobe = 1'b0; #1;
    check("R8 register unchanged", {8'h0, memCtrl}, 16'h005A);
    @(negedge clk);
    mode = 3'd3; portAddr = 16'h0000; wrData = 8'hC3; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0; #1;
    check("R10 memCtrl updated in mode 3", {8'h0, memCtrl}, 16'h00C3);
  endtask

  task automatic testMasks();
    @(negedge clk);
    maskLoad = 1'b1; maskUpIn = 8'h0F; maskDownIn = 8'h81;
    @(negedge clk);
    maskLoad = 1'b0; maskUpIn = 8'h00; maskDownIn = 8'h00;
    mode = 3'd0; portAddr = 16'h0020; lastOpcode = 8'hF0; rdStrobe = 1'b1; #1;
    check("R9 masked open bus", {8'h0, rdData}, 16'h007E);
    mode = 3'd3; portAddr = 16'h00C5; lastOpcode = 8'h00; #1;
    check("R9 R7 masked open bus in pad region", {8'h0, rdData}, 16'h000E);
    rdStrobe = 1'b0; #1;
    check("R11 strobe low", {8'h0, rdData}, 16'h0000);
    lastOpcode = 8'h9C;
  endtask

  task automatic testNoStrobe();
    @(negedge clk);
    mode = 3'd1; portAddr = 16'h00F0; wrStrobe = 1'b0; rdStrobe = 1'b0; #1;
    check("R10 no select without strobe", {9'h0, selVec()}, 16'h0000);
    portAddr = 16'h0000; mode = 3'd0; wrData = 8'hEE;
    @(negedge clk); #1;
    check("R10 memCtrl holds without strobe", {8'h0, memCtrl}, 16'h00C3);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testReset();
    sweepWrites();
    sweepReads(8'h00);
    sweepReads(8'h04);
    testFmGate();
    testWideMemCtrl();
    testNoStrobe();
    testMasks();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule